// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small store of upcoming instruction bytes ahead of the decoder. It forms a 20-bit code fetch address from a 16-bit code segment value and a 16-bit instruction pointer. When the store has room for a whole word, it asks a 16-bit fetch port for that word. Each returned word goes into the store as two bytes. The decoder takes bytes out one at a time. On each byte it takes, the decoder says whether that byte opens a new instruction or continues the current one.

A branch input empties the store and loads a new segment and pointer pair, so fetching restarts at the target. A two-bit status output reports, one cycle later, what happened to the store in each cycle. The fetch request and the byte output are valid/ready streams. The fetch request holds its address while it waits for ready. Only one word fetch is in flight at a time. The fetch return port raises ready only while a fetch is in flight, and the fetch port must not present return data at any other time. The byte output offers a byte whenever one is stored. The decoder may hold ready low for as long as it likes and nothing is lost.

Top module: `code_prefetch_queue`

## Requirements
- R1: After reset the store is empty (`byte_valid_o`=0), the status reads 00, `fr_ready_o`=0, and a fetch is requested at the reset segment/pointer address (default 0xFFFF0).
- R2: Bytes leave in the order they arrived. Each returned word puts bits 7:0 into the store ahead of bits 15:8.
- R3: The store never holds more than 6 bytes. A read request while the store is empty removes nothing and reports status 00.
- R4: A fetch is requested only when at least 2 of the 6 slots are free and no fetch is in flight. With 5 bytes held, no request is made until one is read.
- R5: The fetch address is (segment × 16 + pointer) modulo 2^20.
- R6: The pointer advances by 2 on each accepted fetch request and wraps modulo 2^16.
- R7: A branch empties the store and loads the new segment and pointer. The next request is made at the target address.
- R8: The status shows, in the cycle after the event, 01 for a byte read with the opcode-start flag set, 11 for a byte read without it, 10 for a branch flush, and 00 for no read.
- R9: When a branch and a read request fall in the same cycle, the branch wins. `byte_valid_o` is 0 in that cycle and no byte is consumed.
- R10: A word that returns for a fetch issued before a branch is accepted from the fetch port and then dropped. The store stays empty.
- R11: While a request waits for ready, its address stays steady. Return data is taken only while a fetch is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| branch_i | input | 1 | Flush the store and load a new target |
| branch_seg_i | input | 16 | Target code segment |
| branch_ip_i | input | 16 | Target instruction pointer |
| fq_valid_o | output | 1 | Word fetch request valid |
| fq_ready_i | input | 1 | Fetch port accepts the request |
| fq_addr_o | output | 20 | Fetch byte address |
| fr_valid_i | input | 1 | Returned fetch word valid |
| fr_ready_o | output | 1 | Return data accepted (a fetch is in flight) |
| fr_data_i | input | 16 | Returned fetch word |
| byte_valid_o | output | 1 | A byte is offered to the decoder |
| byte_ready_i | input | 1 | Decoder takes the offered byte |
| op_start_i | input | 1 | The byte taken opens a new instruction |
| byte_o | output | 8 | Oldest stored byte |
| qs_o | output | 2 | Status of the previous cycle's store operation |

## Verification
The bench fills the store until it has exactly one free slot. A design that fetched with a single free slot would raise a request there and overflow the store on return. A branch is issued while a fetch is in flight. A design that kept the late word would show stale bytes after the flush. A branch is also raised in the same cycle as a read. A design that let the read win would report status 01 or 11 instead of 10, or lose a byte. Addresses are checked at the segment and pointer wrap corners, where a design that kept a carry beyond 20 or 16 bits would put out the wrong fetch address.

// File: rtl/cpq_pkg.sv
package cpq_pkg;
  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qs_e;
endpackage

// File: rtl/cpq_pointer.sv
module cpq_pointer #(
  parameter int SEG_W  = 16,
  parameter int OFS_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20,
  parameter int STEP   = 2,
  parameter logic [SEG_W-1:0] RESET_SEG = '1,
  parameter logic [OFS_W-1:0] RESET_OFS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SEG_W-1:0]  load_seg,
  input  logic [OFS_W-1:0]  load_ofs,
  input  logic              advance,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int BASE_W = SEG_W + SHIFT;

  logic [SEG_W-1:0]  seg_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [BASE_W-1:0] base_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q <= RESET_SEG;
      ofs_q <= RESET_OFS;
    end else if (load) begin
      seg_q <= load_seg;
      ofs_q <= load_ofs;
    end else if (advance) begin
      ofs_q <= ofs_q + OFS_W'(STEP);
    end
  end

  assign base_w = {seg_q, {SHIFT{1'b0}}};
  assign addr_o = ADDR_W'(base_w) + ADDR_W'(ofs_q);
  assign ofs_o  = ofs_q;
endmodule

// File: rtl/cpq_ring.sv
module cpq_ring #(
  parameter int DEPTH  = 6,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    wr_en,
  input  logic [LANES*BYTE_W-1:0] wr_data,
  input  logic                    rd_req,
  output logic                    rd_valid,
  output logic                    rd_fire,
  output logic [BYTE_W-1:0]       rd_data,
  output logic [CW-1:0]           count_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wptr_q, rptr_q;
  logic [CW-1:0]     cnt_q;
  logic [PW-1:0]     lane_idx [LANES];

  function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] p, input int n);
    logic [PW:0] s;
    s = {1'b0, p} + (PW+1)'(n);
    if (s >= (PW+1)'(DEPTH)) s = s - (PW+1)'(DEPTH);
    return s[PW-1:0];
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_idx[l] = wrap_add(wptr_q, l);
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_en && lane_idx[l] == PW'(e))
          mem_q[e] <= wr_data[l*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rd_valid = (cnt_q != '0) && !flush;
  assign rd_fire  = rd_valid && rd_req;
  assign rd_data  = mem_q[rptr_q];
  assign count_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en)   wptr_q <= wrap_add(wptr_q, LANES);
      if (rd_fire) rptr_q <= wrap_add(rptr_q, 1);
      cnt_q <= cnt_q + (wr_en ? CW'(LANES) : CW'(0)) - (rd_fire ? CW'(1) : CW'(0));
    end
  end
endmodule

// File: rtl/cpq_fetch_ctl.sv
module cpq_fetch_ctl #(
  parameter int DEPTH = 6,
  parameter int LANES = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] count,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_fire,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  output logic          store_en
);
  localparam logic [CW-1:0] FILL_LIMIT = CW'(DEPTH - LANES);

  logic pending_q, stale_q, room_w, rsp_fire;

  assign room_w    = count <= FILL_LIMIT;
  assign req_valid = !pending_q && room_w && !flush;
  assign req_fire  = req_valid && req_ready;
  assign rsp_ready = pending_q;
  assign rsp_fire  = rsp_valid && pending_q;
  assign store_en  = rsp_fire && !stale_q && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      stale_q   <= 1'b0;
    end else begin
      if (rsp_fire)      pending_q <= 1'b0;
      else if (req_fire) pending_q <= 1'b1;
      if (rsp_fire)                   stale_q <= 1'b0;
      else if (flush && pending_q)    stale_q <= 1'b1;
    end
  end
endmodule

// File: rtl/code_prefetch_queue.sv
module code_prefetch_queue #(
  parameter int SEG_W  = 16,
  parameter int OFS_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  parameter int DEPTH  = 6,
  parameter logic [SEG_W-1:0] RESET_SEG = '1,
  parameter logic [OFS_W-1:0] RESET_OFS = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    branch_i,
  input  logic [SEG_W-1:0]        branch_seg_i,
  input  logic [OFS_W-1:0]        branch_ip_i,
  output logic                    fq_valid_o,
  input  logic                    fq_ready_i,
  output logic [ADDR_W-1:0]       fq_addr_o,
  input  logic                    fr_valid_i,
  output logic                    fr_ready_o,
  input  logic [LANES*BYTE_W-1:0] fr_data_i,
  output logic                    byte_valid_o,
  input  logic                    byte_ready_i,
  input  logic                    op_start_i,
  output logic [BYTE_W-1:0]       byte_o,
  output logic [1:0]              qs_o
);
  import cpq_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]    occ_w;
  logic [OFS_W-1:0] ip_w;
  logic             req_fire_w, store_w, rd_fire_w;
  qs_e              qs_q;

  cpq_pointer #(
    .SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W),
    .STEP(LANES), .RESET_SEG(RESET_SEG), .RESET_OFS(RESET_OFS)
  ) ptr_i (
    .clk(clk), .rst_n(rst_n), .load(branch_i), .load_seg(branch_seg_i),
    .load_ofs(branch_ip_i), .advance(req_fire_w), .ofs_o(ip_w), .addr_o(fq_addr_o)
  );

  cpq_fetch_ctl #(.DEPTH(DEPTH), .LANES(LANES)) ctl_i (
    .clk(clk), .rst_n(rst_n), .flush(branch_i), .count(occ_w),
    .req_valid(fq_valid_o), .req_ready(fq_ready_i), .req_fire(req_fire_w),
    .rsp_valid(fr_valid_i), .rsp_ready(fr_ready_o), .store_en(store_w)
  );

  cpq_ring #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .LANES(LANES)) ring_i (
    .clk(clk), .rst_n(rst_n), .flush(branch_i), .wr_en(store_w), .wr_data(fr_data_i),
    .rd_req(byte_ready_i), .rd_valid(byte_valid_o), .rd_fire(rd_fire_w),
    .rd_data(byte_o), .count_o(occ_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         qs_q <= QS_IDLE;
    else if (branch_i)  qs_q <= QS_FLUSH;
    else if (rd_fire_w) qs_q <= op_start_i ? QS_FIRST : QS_NEXT;
    else                qs_q <= QS_IDLE;
  end

  assign qs_o = qs_q;
endmodule

// File: rtl/cpq_checker.sv
module cpq_checker #(
  parameter int DEPTH  = 6,
  parameter int OFS_W  = 16,
  parameter int ADDR_W = 20,
  parameter int LANES  = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              branch_i,
  input logic              fq_valid_o,
  input logic              fq_ready_i,
  input logic [ADDR_W-1:0] fq_addr_o,
  input logic              byte_valid_o,
  input logic [1:0]        qs_o,
  input logic [CW-1:0]     occ,
  input logic [OFS_W-1:0]  ip_cur
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));
  p_empty_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !byte_valid_o);
  p_req_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fq_valid_o |-> (occ <= CW'(DEPTH - LANES)));
  p_ip_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fq_valid_o && fq_ready_i && !branch_i) |=> (ip_cur == $past(ip_cur) + OFS_W'(LANES)));
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    branch_i |=> (occ == '0));
  p_flush_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    branch_i |=> (qs_o == 2'b10));
  p_flush_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    branch_i |-> !byte_valid_o);
  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fq_valid_o && !fq_ready_i && !branch_i) |=> $stable(fq_addr_o));
endmodule

bind code_prefetch_queue cpq_checker #(
  .DEPTH(DEPTH), .OFS_W(OFS_W), .ADDR_W(ADDR_W), .LANES(LANES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .branch_i(branch_i), .fq_valid_o(fq_valid_o),
  .fq_ready_i(fq_ready_i), .fq_addr_o(fq_addr_o), .byte_valid_o(byte_valid_o),
  .qs_o(qs_o), .occ(occ_w), .ip_cur(ip_w)
);

// File: tb/code_prefetch_queue_tb_top.sv
module code_prefetch_queue_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        branch_i = 1'b0;
  logic [15:0] branch_seg_i = '0, branch_ip_i = '0;
  logic        fq_valid_o, fq_ready_i = 1'b0;
  logic [19:0] fq_addr_o;
  logic        fr_valid_i = 1'b0, fr_ready_o;
  logic [15:0] fr_data_i = '0;
  logic        byte_valid_o, byte_ready_i = 1'b0, op_start_i = 1'b0;
  logic [7:0]  byte_o;
  logic [1:0]  qs_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  code_prefetch_queue dut_i (
    .clk(clk), .rst_n(rst_n), .branch_i(branch_i), .branch_seg_i(branch_seg_i),
    .branch_ip_i(branch_ip_i), .fq_valid_o(fq_valid_o), .fq_ready_i(fq_ready_i),
    .fq_addr_o(fq_addr_o), .fr_valid_i(fr_valid_i), .fr_ready_o(fr_ready_o),
    .fr_data_i(fr_data_i), .byte_valid_o(byte_valid_o), .byte_ready_i(byte_ready_i),
    .op_start_i(op_start_i), .byte_o(byte_o), .qs_o(qs_o)
  );

  // each entry: {segment, pointer, expected address}
  localparam logic [51:0] ADDR_TAB [4] = '{
    52'hFFFFFFF00FFE0,
    52'h345A13DC3597C,
    52'h0000FFFF0FFFF,
    52'h1234000512345
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic do_branch(input logic [15:0] seg, input logic [15:0] ip);
    branch_i = 1'b1; branch_seg_i = seg; branch_ip_i = ip;
    tick();
    branch_i = 1'b0;
    #1;
  endtask

  // handshake one request, then return the word: byte at address a holds a[7:0]
  task automatic do_fetch(input string req, input logic [19:0] exp_addr);
    check(req, {31'b0, fq_valid_o}, 32'd1);
    check(req, {12'b0, fq_addr_o}, {12'b0, exp_addr});
    fq_ready_i = 1'b1;
    tick();
    fq_ready_i = 1'b0;
    check("R4 busy", {31'b0, fq_valid_o}, 32'd0);
    fr_valid_i = 1'b1;
    fr_data_i = {exp_addr[7:0] + 8'd1, exp_addr[7:0]};
    #1;
    check("R11 rsp ready", {31'b0, fr_ready_o}, 32'd1);
    tick();
    fr_valid_i = 1'b0;
    #1;
  endtask

  task automatic do_read(input logic [7:0] exp, input logic first);
    check("R2 valid", {31'b0, byte_valid_o}, 32'd1);
    check("R2 order", {24'b0, byte_o}, {24'b0, exp});
    byte_ready_i = 1'b1; op_start_i = first;
    tick();
    byte_ready_i = 1'b0; op_start_i = 1'b0;
    #1;
    check("R8 read code", {30'b0, qs_o}, first ? 32'd1 : 32'd3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 empty", {31'b0, byte_valid_o}, 32'd0);
    check("R1 status", {30'b0, qs_o}, 32'd0);
    check("R1 no rsp ready", {31'b0, fr_ready_o}, 32'd0);
    check("R1 req", {31'b0, fq_valid_o}, 32'd1);
    check("R1 addr", {12'b0, fq_addr_o}, 32'h000FFFF0);

    // R5 address table walk (requests never accepted here)
    for (int k = 0; k < 4; k++) begin
      do_branch(ADDR_TAB[k][51:36], ADDR_TAB[k][35:20]);
      check("R8 flush code", {30'b0, qs_o}, 32'd2);
      check("R7 req at target", {31'b0, fq_valid_o}, 32'd1);
      check("R5 addr", {12'b0, fq_addr_o}, {12'b0, ADDR_TAB[k][19:0]});
      tick(); tick();
      check("R11 addr hold", {12'b0, fq_addr_o}, {12'b0, ADDR_TAB[k][19:0]});
    end

    // fill the store with three words
    do_branch(16'h0000, 16'h0010);
    do_fetch("R7 first fetch", 20'h00010);
    do_fetch("R6 step", 20'h00012);
    do_fetch("R6 step", 20'h00014);
    check("R4 full no req", {31'b0, fq_valid_o}, 32'd0);
    do_read(8'h10, 1'b1);
    check("R4 one free no req", {31'b0, fq_valid_o}, 32'd0);
    do_read(8'h11, 1'b0);
    check("R4 two free req", {31'b0, fq_valid_o}, 32'd1);
    check("R6 next addr", {12'b0, fq_addr_o}, 32'h00016);
    do_read(8'h12, 1'b1);
    do_read(8'h13, 1'b0);
    do_read(8'h14, 1'b0);
    do_read(8'h15, 1'b0);
    check("R3 empty", {31'b0, byte_valid_o}, 32'd0);
    byte_ready_i = 1'b1;
    tick();
    byte_ready_i = 1'b0;
    #1;
    check("R3 empty read code", {30'b0, qs_o}, 32'd0);
    check("R3 still empty", {31'b0, byte_valid_o}, 32'd0);

    // R10 stale return after branch
    fq_ready_i = 1'b1;
    tick();
    fq_ready_i = 1'b0;
    do_branch(16'h0000, 16'h0100);
    check("R10 pending held", {31'b0, fq_valid_o}, 32'd0);
    check("R10 rsp ready", {31'b0, fr_ready_o}, 32'd1);
    fr_valid_i = 1'b1; fr_data_i = 16'h1716;
    tick();
    fr_valid_i = 1'b0;
    #1;
    check("R10 dropped", {31'b0, byte_valid_o}, 32'd0);
    check("R10 refetch target", {12'b0, fq_addr_o}, 32'h00100);

    // R9 flush beats read
    do_fetch("R7 fetch", 20'h00100);
    byte_ready_i = 1'b1; op_start_i = 1'b1;
    branch_i = 1'b1; branch_seg_i = 16'h0000; branch_ip_i = 16'hFFFE;
    #1;
    check("R9 no byte in flush", {31'b0, byte_valid_o}, 32'd0);
    tick();
    branch_i = 1'b0; byte_ready_i = 1'b0; op_start_i = 1'b0;
    #1;
    check("R9 flush code", {30'b0, qs_o}, 32'd2);
    check("R9 emptied", {31'b0, byte_valid_o}, 32'd0);

    // R6 pointer wrap
    do_fetch("R6 wrap fetch", 20'h0FFFE);
    check("R6 wrapped addr", {12'b0, fq_addr_o}, 32'h00000);
    do_read(8'hFE, 1'b1);
    do_read(8'hFF, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule